// File: doc/BRIEF.md
# Dual Halfword Multiply-Subtract Unit

This execution-stage datapath unit treats each of two 32-bit source operands as a pair of signed 16-bit halfwords. It multiplies the low halfwords together and the high halfwords together. It then subtracts the high-half product from the low-half product and returns the 32-bit result one clock later. A mode bit first exchanges the halfwords of the second operand, so the two products become cross terms (low × high and high × low).

The unit also carries the issue bookkeeping that the writeback stage needs. It registers the destination index. It checks whether any of the three register indices names the reserved index 15 and reports that as an unpredictable operation. It raises a write-enable only for an issued, condition-passed and predictable operation. The difference of two 16×16 signed products always fits in 32 signed bits, so the unit produces no overflow or saturation indication.

Top module: `dual_mulsub_unit`

## Requirements
- R1: With `xchg_mode` = 0, the result is (signed a[15:0] × signed b[15:0]) − (signed a[31:16] × signed b[31:16]), taken as bits 31:0. It appears on `res_data` on the rising edge after the one that sampled `issue_valid` = 1.
- R2: With `xchg_mode` = 1, operand b is rotated by 16 bits before use. The result is then (signed a[15:0] × signed b[31:16]) − (signed a[31:16] × signed b[15:0]), with the same timing as R1.
- R3: Extreme operands (−32768 × −32768 and −32768 × 32767, in both modes) give the exact mathematical difference in 32 signed bits. No overflow output exists.
- R4: `res_valid` is 1 on exactly the cycle after a cycle in which `issue_valid` was sampled high, and is 0 otherwise.
- R5: `res_dst` presents the `dst_idx` sampled with the issued operation.
- R6: `res_unpred` is 1 for an issued operation when `dst_idx`, `srca_idx` or `srcb_idx` equals 15, and is 0 otherwise.
- R7: `res_wr_en` is 1 only when the issued operation had `cond_pass` = 1 and `res_unpred` is 0.
- R8: While `issue_valid` is 0, `res_data`, `res_dst` and `res_unpred` keep their previous values.
- R9: Synchronous active-high `rst` sets `res_valid`, `res_wr_en` and `res_unpred` to 0, and sets `res_data` and `res_dst` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Operation issued this cycle |
| cond_pass | input | 1 | Condition check passed for this operation |
| xchg_mode | input | 1 | 0 = plain products, 1 = exchange halfwords of operand b |
| srca_idx | input | 4 | Register index of operand a |
| srcb_idx | input | 4 | Register index of operand b |
| dst_idx | input | 4 | Destination register index |
| opnd_a | input | 32 | Operand a |
| opnd_b | input | 32 | Operand b |
| res_valid | output | 1 | Result stage holds an issued operation |
| res_wr_en | output | 1 | Register write permitted |
| res_unpred | output | 1 | A register index equal to 15 was used |
| res_dst | output | 4 | Destination index of the result |
| res_data | output | 32 | Difference of the two products |

## Verification
A failed condition check and an unpredictable register index both gate the write, and they can arrive on the same issued operation. The bench issues operations with `cond_pass` low and an index of 15 together, as well as each on its own. It expects `res_wr_en` low in all three cases. It also expects `res_unpred` to follow only the index check, and `res_data` to still carry the correct difference, so it can tell that neither gate masks the other.

// File: rtl/dms_pkg.sv
package dms_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned PROD_W = 2 * HALF_W;
  localparam int unsigned DIFF_W = PROD_W + 1;

  typedef logic signed [HALF_W-1:0] half_t;
  typedef logic signed [PROD_W-1:0] prod_t;
  typedef logic signed [DIFF_W-1:0] diff_t;

  // Exchange the two halfwords of a word when sel is set.
  function automatic logic [DATA_W-1:0] halves_xchg(input logic [DATA_W-1:0] w,
                                                    input logic sel);
    return sel ? {w[HALF_W-1:0], w[DATA_W-1:HALF_W]} : w;
  endfunction

  // Signed product of two halfwords.
  function automatic prod_t half_mul(input half_t x, input half_t y);
    prod_t r;
    r = prod_t'(x) * prod_t'(y);
    return r;
  endfunction

  // Exact difference of two products, one bit wider than either.
  function automatic diff_t prod_sub(input prod_t p_lo, input prod_t p_hi);
    return diff_t'(p_lo) - diff_t'(p_hi);
  endfunction
endpackage

// File: rtl/dms_operand_route.sv
module dms_operand_route
  import dms_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] b_in,
  input  logic         xchg,
  output logic [W-1:0] b_out
);
  localparam int unsigned H = W / 2;

  for (genvar g = 0; g < 2; g++) begin : g_half
    localparam int unsigned OWN   = g * H;
    localparam int unsigned OTHER = (1 - g) * H;
    assign b_out[OWN +: H] = xchg ? b_in[OTHER +: H] : b_in[OWN +: H];
  end
endmodule

// File: rtl/dms_product_pair.sv
module dms_product_pair
  import dms_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] diff_out,
  output logic              fits_w
);
  prod_t prod [2];
  diff_t exact;

  for (genvar g = 0; g < 2; g++) begin : g_mul
    assign prod[g] = half_mul(half_t'(a[g*HALF_W +: HALF_W]),
                              half_t'(b[g*HALF_W +: HALF_W]));
  end

  assign exact    = prod_sub(prod[0], prod[1]);
  assign diff_out = exact[DATA_W-1:0];
  // Exact value survives truncation when the two top bits agree.
  assign fits_w   = (exact[DIFF_W-1] == exact[DIFF_W-2]);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) fits_w)
    else $error("difference does not fit in 32 signed bits");
endmodule

// File: rtl/dms_reg_guard.sv
module dms_reg_guard #(
  parameter int unsigned IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx_d,
  input  logic [IDX_W-1:0] idx_a,
  input  logic [IDX_W-1:0] idx_b,
  output logic             unpred
);
  localparam logic [IDX_W-1:0] RESERVED = {IDX_W{1'b1}};
  logic [IDX_W-1:0] idx [3];
  logic [2:0]       hit;

  assign idx[0] = idx_d;
  assign idx[1] = idx_a;
  assign idx[2] = idx_b;

  for (genvar g = 0; g < 3; g++) begin : g_cmp
    assign hit[g] = (idx[g] == RESERVED);
  end

  assign unpred = |hit;
endmodule

// File: rtl/dual_mulsub_unit.sv
module dual_mulsub_unit
  import dms_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic              cond_pass,
  input  logic              xchg_mode,
  input  logic [IDX_W-1:0]  srca_idx,
  input  logic [IDX_W-1:0]  srcb_idx,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              res_valid,
  output logic              res_wr_en,
  output logic              res_unpred,
  output logic [IDX_W-1:0]  res_dst,
  output logic [DATA_W-1:0] res_data
);
  logic [DATA_W-1:0] b_routed;
  logic [DATA_W-1:0] diff_w;
  logic              fits_w;
  logic              unpred_w;
  logic              write_ok_w;

  dms_operand_route #(.W(DATA_W)) u_route (
    .b_in (opnd_b),
    .xchg (xchg_mode),
    .b_out(b_routed)
  );

  dms_product_pair u_prod (
    .clk     (clk),
    .rst     (rst),
    .a       (opnd_a),
    .b       (b_routed),
    .diff_out(diff_w),
    .fits_w  (fits_w)
  );

  dms_reg_guard #(.IDX_W(IDX_W)) u_guard (
    .idx_d (dst_idx),
    .idx_a (srca_idx),
    .idx_b (srcb_idx),
    .unpred(unpred_w)
  );

  assign write_ok_w = issue_valid && cond_pass && !unpred_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_wr_en  <= 1'b0;
      res_unpred <= 1'b0;
      res_dst    <= '0;
      res_data   <= '0;
    end else begin
      res_valid <= issue_valid;
      res_wr_en <= write_ok_w;
      if (issue_valid) begin
        res_unpred <= unpred_w;
        res_dst    <= dst_idx;
        res_data   <= diff_w;
      end
    end
  end

  // R4
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    issue_valid |=> res_valid) else $error("result valid missing");
  // R4
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> !res_valid) else $error("spurious result valid");
  // R7
  wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    res_wr_en |-> (res_valid && !res_unpred)) else $error("ungated write");
  // R6
  unpred_dst_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && dst_idx == {IDX_W{1'b1}}) |=> res_unpred)
    else $error("reserved destination not flagged");
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> ($stable(res_data) && $stable(res_dst)))
    else $error("result changed while idle");
endmodule

// File: tb/sim_dual_mulsub_unit.sv
module sim_dual_mulsub_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  // {mode, a, b, expected}
  localparam logic [96:0] VTAB [NVEC] = '{
    {1'b0, 32'h0003_0002, 32'h0005_0007, 32'hFFFF_FFFF},
    {1'b1, 32'h0003_0002, 32'h0005_0007, 32'hFFFF_FFF5},
    {1'b0, 32'h8000_8000, 32'h8000_8000, 32'h0000_0000},
    {1'b1, 32'h8000_8000, 32'h8000_8000, 32'h0000_0000},
    {1'b0, 32'h7FFF_8000, 32'h8000_8000, 32'h7FFF_8000},
    {1'b1, 32'h7FFF_8000, 32'h8000_7FFF, 32'h0000_FFFF},
    {1'b0, 32'h8000_7FFF, 32'h7FFF_8000, 32'h0000_0000},
    {1'b1, 32'h8000_7FFF, 32'h8000_8000, 32'h8000_8000},
    {1'b0, 32'hFFFF_0001, 32'h0002_FFFF, 32'h0000_0001}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic        cond_pass = 1'b0;
  logic        xchg_mode = 1'b0;
  logic [3:0]  srca_idx = 4'd1;
  logic [3:0]  srcb_idx = 4'd2;
  logic [3:0]  dst_idx = 4'd3;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic        res_valid, res_wr_en, res_unpred;
  logic [3:0]  res_dst;
  logic [31:0] res_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_mulsub_unit u0 (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .cond_pass(cond_pass),
    .xchg_mode(xchg_mode), .srca_idx(srca_idx), .srcb_idx(srcb_idx),
    .dst_idx(dst_idx), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .res_valid(res_valid), .res_wr_en(res_wr_en), .res_unpred(res_unpred),
    .res_dst(res_dst), .res_data(res_data)
  );

  // Independent reference: product of sign-extended halves in 64-bit arithmetic.
  function automatic logic [31:0] model(input logic m, input logic [31:0] a,
                                        input logic [31:0] b);
    longint al, ah, bl, bh, r;
    al = longint'($signed(a[15:0]));
    ah = longint'($signed(a[31:16]));
    bl = longint'($signed(m ? b[31:16] : b[15:0]));
    bh = longint'($signed(m ? b[15:0] : b[31:16]));
    r = al * bl - ah * bh;
    return r[31:0];
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic m, input logic [31:0] a, input logic [31:0] b,
                       input logic cp, input logic [3:0] d, input logic [3:0] sa,
                       input logic [3:0] sb);
    issue_valid = 1'b1; xchg_mode = m; opnd_a = a; opnd_b = b;
    cond_pass = cp; dst_idx = d; srca_idx = sa; srcb_idx = sb;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 valid", res_valid, 0);
    chk("R9 wr_en", res_wr_en, 0);
    chk("R9 unpred", res_unpred, 0);
    chk("R9 data", res_data, 0);
    chk("R9 dst", res_dst, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R4 idle", res_valid, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [96:0] v;
      v = VTAB[i];
      issue(v[96], v[95:64], v[63:32], 1'b1, 4'(i % 8 + 4), 4'd1, 4'd2);
      // R1 R2 R3: table value and model value
      chk(v[96] ? "R2 xchg" : "R1 plain", res_data, v[31:0]);
      chk("R3 model", res_data, model(v[96], v[95:64], v[63:32]));
      chk("R4 valid", res_valid, 1);
      chk("R5 dst", res_dst, i % 8 + 4);
      chk("R7 wr_en", res_wr_en, 1);
      chk("R6 clean", res_unpred, 0);
    end

    // R8: idle cycle keeps result, valid drops
    @(negedge clk);
    chk("R4 drop", res_valid, 0);
    chk("R8 hold data", res_data, 32'h0000_0001);
    chk("R8 hold dst", res_dst, 4'd4);
    chk("R7 idle wr", res_wr_en, 0);

    // R6: each index at 15 in turn
    issue(1'b0, 32'h0003_0002, 32'h0005_0007, 1'b1, 4'd15, 4'd1, 4'd2);
    chk("R6 dst15", res_unpred, 1); chk("R7 dst15", res_wr_en, 0);
    chk("R5 dst15", res_dst, 15);
    issue(1'b0, 32'h0003_0002, 32'h0005_0007, 1'b1, 4'd5, 4'd15, 4'd2);
    chk("R6 srca15", res_unpred, 1); chk("R7 srca15", res_wr_en, 0);
    issue(1'b1, 32'h0003_0002, 32'h0005_0007, 1'b1, 4'd5, 4'd1, 4'd15);
    chk("R6 srcb15", res_unpred, 1); chk("R7 srcb15", res_wr_en, 0);
    chk("R2 under unpred", res_data, 32'hFFFF_FFF5);

    // R7: condition fail alone, then with unpredictable index
    issue(1'b0, 32'h0003_0002, 32'h0005_0007, 1'b0, 4'd6, 4'd1, 4'd2);
    chk("R7 condfail", res_wr_en, 0); chk("R6 condfail", res_unpred, 0);
    chk("R4 condfail", res_valid, 1); chk("R1 condfail", res_data, 32'hFFFF_FFFF);
    issue(1'b1, 32'h8000_7FFF, 32'h8000_8000, 1'b0, 4'd15, 4'd1, 4'd2);
    chk("R7 both", res_wr_en, 0); chk("R6 both", res_unpred, 1);
    chk("R3 both", res_data, 32'h8000_8000);

    // R8: unpred flag held while idle
    @(negedge clk);
    chk("R8 hold unpred", res_unpred, 1);

    // R9: reset mid-stream
    issue_valid = 1'b1; cond_pass = 1'b1; dst_idx = 4'd7; rst = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0; rst = 1'b0;
    chk("R9 valid mid", res_valid, 0); chk("R9 wr mid", res_wr_en, 0);
    chk("R9 unpred mid", res_unpred, 0); chk("R9 data mid", res_data, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule